// File: doc/BRIEF.md
# Grant Flag and Interrupt Re-arm Controller

This block sits beside a hardware semaphore array shared by several processor cores (masters). Whenever the array hands a slot to a master through its queued path, it presents a grant event here. The block records each such grant as a bit in a per-master flag word and tells that master through a dedicated grant interrupt line.

Each interrupt line is one-shot. After it pulses, it stays quiet until the master writes its own code to the end-of-interrupt register. Software clears flag bits with write-1-to-clear and can force bits on through a separate write-only set register. The end-of-interrupt register also carries a re-arm command for the error interrupts. This block does not act on that command; it passes it on to the error logic as a one-cycle pulse.

The register bus is a single-cycle request port: writes take effect at the clock edge, and read data is returned combinationally in the same cycle. Word address map with the defaults (N_MASTERS=3): the flag word of master m is at m, the set register of master m is at 4+m, and the end-of-interrupt register is at 8.

Top module: `gnt_flag_irq`

## Requirements
- R1: After reset every flag word reads 0, no grant interrupt is asserted, and every line is armed.
- R2: A grant event for master m on slot y sets bit y of master m's flag word at the next clock edge.
- R3: A write to the flag word of master m (address m) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to the set register of master m (address 4+m) sets each bit written as 1 in master m's flag word. A read of a set register returns 0.
- R5: If a bit is cleared by a write in the same cycle that a grant event or a set write targets it, the bit ends up set.
- R6: While a master's line is armed and its flag word is non-zero, its grant interrupt is high for exactly one cycle, and the line is then disarmed. The pulse follows one cycle after the edge that made the flag word non-zero. Further grants cause no pulse while the line is disarmed.
- R7: A write to the end-of-interrupt register (address 8) whose bits 7:0 equal m re-arms master m's line. If that master's flag word is still non-zero, a new pulse follows in the cycle after the write; otherwise the next grant fires it.
- R8: An end-of-interrupt write with bits 7:0 = 0x10 produces a one-cycle pulse on err_rearm_o in the cycle after the write, and re-arms no grant line.
- R9: Only bits 7:0 of an end-of-interrupt write are decoded; any value there other than a master index or 0x10 has no effect.
- R10: A read of the end-of-interrupt address raises rerr_o in the same cycle with read data 0; reads of other addresses leave rerr_o low.
- R11: A read of address m returns master m's flag word in bits N_SLOTS-1:0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gnt_evt_i | input | N_MASTERS*N_SLOTS | Grant events; bit m*N_SLOTS+y means slot y granted to master m |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, same cycle |
| rerr_o | output | 1 | Read error (end-of-interrupt address read) |
| gnt_irq_o | output | N_MASTERS | One-cycle grant interrupt per master |
| err_rearm_o | output | 1 | One-cycle error-interrupt re-arm command |

## Verification
The bench targets several corner cases. The first is re-arming while flags are still set: a design that waits for a fresh grant would miss the pulse the bench expects the cycle after the write. The second is a grant arriving while the line is disarmed, which would show up as an extra pulse on a design that re-triggers on every event. The bench also covers a clear colliding with a grant on the same bit, which a design that gives the clear priority would lose. Finally, it drives the error re-arm code and unknown codes: a decoder that looks at too few bits, or that ignores the code, would re-arm a grant line or fire err_rearm_o wrongly.

// File: rtl/gfi_pkg.sv
package gfi_pkg;
  typedef enum logic [1:0] {
    RK_FLAG = 2'd0,
    RK_SET  = 2'd1,
    RK_EOI  = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  localparam int unsigned EOI_CODE_W = 8;
  localparam logic [EOI_CODE_W-1:0] EOI_ERR_CODE = 8'h10;
endpackage

// File: rtl/gfi_reg_dec.sv
module gfi_reg_dec
  import gfi_pkg::*;
#(
  parameter int unsigned N_MASTERS = 3,
  parameter int unsigned N_SLOTS   = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 2,
  parameter int unsigned ADDR_W    = IDX_W + 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [N_MASTERS*N_SLOTS-1:0] clr_o,
  output logic [N_MASTERS*N_SLOTS-1:0] set_o,
  output logic [N_MASTERS-1:0]         rearm_o,
  output logic                         err_rearm_o,
  output logic                         rd_flag_o,
  output logic [IDX_W-1:0]             rd_idx_o,
  output logic                         rerr_o
);
  reg_kind_e             kind;
  logic [IDX_W-1:0]      idx;
  logic                  idx_ok;
  logic                  wr;
  logic                  is_eoi;
  logic [EOI_CODE_W-1:0] code;
  logic                  err_rearm_q;

  assign kind   = reg_kind_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx    = addr_i[IDX_W-1:0];
  assign idx_ok = (32'(idx) < N_MASTERS);
  assign wr     = req_i && we_i;
  assign is_eoi = (kind == RK_EOI) && (idx == '0);
  assign code   = wdata_i[EOI_CODE_W-1:0];

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_mst
    logic hit;
    assign hit = wr && idx_ok && (32'(idx) == m);
    assign clr_o[m*N_SLOTS +: N_SLOTS] = (hit && kind == RK_FLAG) ? wdata_i[N_SLOTS-1:0] : '0;
    assign set_o[m*N_SLOTS +: N_SLOTS] = (hit && kind == RK_SET)  ? wdata_i[N_SLOTS-1:0] : '0;
    assign rearm_o[m] = wr && is_eoi && (32'(code) == m);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_rearm_q <= 1'b0;
    else         err_rearm_q <= wr && is_eoi && (code == EOI_ERR_CODE);
  end
  assign err_rearm_o = err_rearm_q;

  assign rd_flag_o = req_i && !we_i && (kind == RK_FLAG) && idx_ok;
  assign rd_idx_o  = idx;
  assign rerr_o    = req_i && !we_i && is_eoi;

  a_r8_err_rearm_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && is_eoi && wdata_i[7:0] == 8'h10) |=> err_rearm_o);
  a_r8_err_rearm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && is_eoi) |=> !err_rearm_o);
  a_r10_rerr_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> (req_i && !we_i));
  a_r9_rearm_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rearm_o));
endmodule

// File: rtl/gfi_bank.sv
module gfi_bank #(
  parameter int unsigned N_SLOTS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] gnt_i,
  input  logic [N_SLOTS-1:0] clr_i,
  input  logic [N_SLOTS-1:0] set_i,
  input  logic               rearm_i,
  output logic [N_SLOTS-1:0] flag_o,
  output logic               irq_o
);
  logic [N_SLOTS-1:0] flag_q, flag_d;
  logic               armed_q, armed_d;
  logic               fire;

  // set paths win over a same-cycle clear
  assign flag_d = (flag_q & ~clr_i) | set_i | gnt_i;
  assign fire   = armed_q && (|flag_q);
  // an explicit re-arm wins over the self-disarm of a firing line
  assign armed_d = rearm_i ? 1'b1 : (fire ? 1'b0 : armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = fire;

  a_r2_grant_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i != '0) |=> ((flag_q & $past(gnt_i)) == $past(gnt_i)));
  a_r3_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~$past(clr_i) & $past(flag_q) & ~flag_q) == '0));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rearm_i) |=> !irq_o);
  a_r6_quiet_disarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !rearm_i && $past(irq_o)) |=> !irq_o);
endmodule

// File: rtl/gnt_flag_irq.sv
module gnt_flag_irq
  import gfi_pkg::*;
#(
  parameter int unsigned N_MASTERS = 3,
  parameter int unsigned N_SLOTS   = 32,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  localparam int unsigned ADDR_W   = IDX_W + 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_MASTERS*N_SLOTS-1:0] gnt_evt_i,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         rerr_o,
  output logic [N_MASTERS-1:0]         gnt_irq_o,
  output logic                         err_rearm_o
);
  logic [N_MASTERS*N_SLOTS-1:0] clr, set, flags;
  logic [N_MASTERS-1:0]         rearm;
  logic                         rd_flag;
  logic [IDX_W-1:0]             rd_idx;

  gfi_reg_dec #(
    .N_MASTERS(N_MASTERS), .N_SLOTS(N_SLOTS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .clr_o(clr), .set_o(set), .rearm_o(rearm), .err_rearm_o,
    .rd_flag_o(rd_flag), .rd_idx_o(rd_idx), .rerr_o
  );

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_bank
    gfi_bank #(.N_SLOTS(N_SLOTS)) u_bank (
      .clk_i, .rst_ni,
      .gnt_i  (gnt_evt_i[m*N_SLOTS +: N_SLOTS]),
      .clr_i  (clr[m*N_SLOTS +: N_SLOTS]),
      .set_i  (set[m*N_SLOTS +: N_SLOTS]),
      .rearm_i(rearm[m]),
      .flag_o (flags[m*N_SLOTS +: N_SLOTS]),
      .irq_o  (gnt_irq_o[m])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int m = 0; m < N_MASTERS; m++) begin
      if (rd_flag && 32'(rd_idx) == m) rdata_o[N_SLOTS-1:0] = flags[m*N_SLOTS +: N_SLOTS];
    end
  end

  a_r1_no_irq_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (gnt_irq_o == '0));
  a_r10_rerr_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> (rdata_o == '0));
endmodule

// File: tb/tb_gnt_flag_irq.sv
module tb_gnt_flag_irq;
  localparam int NM = 3;
  localparam int NS = 32;
  localparam int ERR_ID = NM;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NM*NS-1:0] gnt_evt_i = '0;
  logic           req_i = 1'b0, we_i = 1'b0;
  logic [3:0]     addr_i = '0;
  logic [31:0]    wdata_i = '0;
  logic [31:0]    rdata_o;
  logic           rerr_o;
  logic [NM-1:0]  gnt_irq_o;
  logic           err_rearm_o;

  gnt_flag_irq dut (.*);

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  typedef struct { int c; int id; } ev_t;
  ev_t q[$];
  logic [NS-1:0] mflag [NM];
  bit            marm  [NM];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts pulses into the queue
  task automatic drive(input logic [NM*NS-1:0] g, input logic rq, input logic w,
                       input logic [3:0] a, input logic [31:0] d);
    gnt_evt_i = g; req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    for (int m = 0; m < NM; m++) begin
      bit fire_now, rearm;
      logic [NS-1:0] clr, st;
      fire_now = marm[m] && (mflag[m] != '0);
      clr = (rq && w && a == 4'(m))     ? d : '0;
      st  = (rq && w && a == 4'(4 + m)) ? d : '0;
      rearm = rq && w && a == 4'd8 && d[7:0] == 8'(m);
      mflag[m] = (mflag[m] & ~clr) | st | g[m*NS +: NS];
      marm[m]  = rearm ? 1'b1 : (fire_now ? 1'b0 : marm[m]);
      if (marm[m] && mflag[m] != '0) q.push_back('{cyc + 1, m});
    end
    if (rq && w && a == 4'd8 && d[7:0] == 8'h10) q.push_back('{cyc + 1, ERR_ID});
  endtask

  task automatic op(input logic [NM*NS-1:0] g, input logic w, input logic [3:0] a,
                    input logic [31:0] d);
    drive(g, w, w, a, d);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op('0, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input bit experr, input string tag);
    drive('0, 1'b1, 1'b0, a, 32'd0);
    #1;
    chk(rdata_o == exp, tag, rdata_o, exp);
    chk(rerr_o == experr, {tag, " rerr"}, rerr_o, experr);
    @(negedge clk_i);
  endtask

  function automatic logic [NM*NS-1:0] gv(input int m, input int y);
    logic [NM*NS-1:0] v = '0;
    v[m*NS + y] = 1'b1;
    return v;
  endfunction

  // monitor: pops predicted pulses as the design produces them
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        while (q.size() > 0 && q[0].c < cyc) begin
          chk(1'b0, q[0].id == ERR_ID ? "R8 missed pulse" : "R6 missed pulse", 0, 1);
          void'(q.pop_front());
        end
        for (int id = 0; id <= NM; id++) begin
          bit obs, exp;
          obs = (id == ERR_ID) ? err_rearm_o : gnt_irq_o[id];
          exp = q.size() > 0 && q[0].c == cyc && q[0].id == id;
          if (exp) void'(q.pop_front());
          if (obs || exp) chk(obs == exp, id == ERR_ID ? "R8 err_rearm" : "R6/R7 irq", obs, exp);
        end
      end
    end
  end

  initial begin
    #(4 * 5000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int m = 0; m < NM; m++) begin mflag[m] = '0; marm[m] = 1'b1; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(gnt_irq_o == '0, "R1 irq", gnt_irq_o, 0);
    rd(4'd0, 32'd0, 1'b0, "R1 flag0");
    rd(4'd2, 32'd0, 1'b0, "R1 flag2");
    // R2 R6 R11 queued grant raises flag and one pulse
    op(gv(1, 5), 1'b0, 4'd0, 32'd0);
    idle(2);
    rd(4'd1, 32'h20, 1'b0, "R2 R11 flag1");
    // R6 disarmed: further grant no pulse
    op(gv(1, 7), 1'b0, 4'd0, 32'd0);
    idle(2);
    rd(4'd1, 32'hA0, 1'b0, "R6 flag1 bits");
    // R3 W1C and write-0 keeps
    op('0, 1'b1, 4'd1, 32'h20);
    rd(4'd1, 32'h80, 1'b0, "R3 clear bit5");
    op('0, 1'b1, 4'd1, 32'h0);
    rd(4'd1, 32'h80, 1'b0, "R3 zero write");
    // R7 re-arm with flag still set fires again
    op('0, 1'b1, 4'd8, 32'h01);
    idle(2);
    // R7 re-arm with empty flags, then grant fires
    op('0, 1'b1, 4'd1, 32'hFFFF_FFFF);
    op('0, 1'b1, 4'd8, 32'h01);
    idle(2);
    rd(4'd1, 32'h0, 1'b0, "R7 flag1 empty");
    op(gv(1, 0), 1'b0, 4'd0, 32'd0);
    idle(2);
    // R4 flag-set register
    op('0, 1'b1, 4'd6, 32'h8000_0001);
    idle(1);
    rd(4'd2, 32'h8000_0001, 1'b0, "R4 flag2 set");
    rd(4'd6, 32'h0, 1'b0, "R4 set reg reads 0");
    // R5 grant vs clear on the same bit, master 0
    op(gv(0, 3), 1'b0, 4'd0, 32'd0);
    idle(1);
    op(gv(0, 3), 1'b1, 4'd0, 32'h8);
    rd(4'd0, 32'h8, 1'b0, "R5 grant beats clear");
    // R8 error re-arm: pulse, master0 stays disarmed
    op('0, 1'b1, 4'd8, 32'h10);
    idle(2);
    // R9 unknown codes ignored
    op('0, 1'b1, 4'd8, 32'h03);
    op('0, 1'b1, 4'd8, 32'h11);
    op('0, 1'b1, 4'd8, 32'hFF);
    idle(2);
    chk(gnt_irq_o == '0 && !err_rearm_o, "R9 no effect", {gnt_irq_o, err_rearm_o}, 0);
    op('0, 1'b1, 4'd8, 32'h00);   // master0 still disarmed before this
    idle(2);
    // R10 EOI read error
    rd(4'd8, 32'h0, 1'b1, "R10 eoi read");
    rd(4'd0, 32'h8, 1'b0, "R10 R11 flag0 no error");
    idle(3);
    chk(q.size() == 0, "R6 queue drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule